// File: doc/BRIEF.md
# Real-Mode Address Relocation Unit

This unit sits on a processor's real-mode load/store path, in front of physical memory. Real-mode requests receive no page translation: each partition sees a private real address space that begins at zero. The unit checks every incoming real address against the partition's size limit. When the address fits, the unit adds the partition's base offset and forwards the relocated request to memory one clock later. When the address does not fit, nothing reaches memory. The unit raises a one-cycle addressing-fault pulse instead.

Three registers hold the partition context: the base offset, the size limit and the physical base of the partition's page table. A configuration write port loads them. Only a write marked privileged takes effect. A write from partition-level code is refused, leaves every register as it was, and produces a one-cycle privilege-fault pulse. After reset the limit is zero, so every real-mode access faults until privileged code has programmed the unit.

Top module: `real_reloc_unit`

## Requirements
- R1: A request with address A below the limit produces memValid high one clock after it is presented. In that cycle memAddr equals (offset + A) modulo 2^PAW, and memWrite equals the request's write flag.
- R2: The range check compares the untranslated address with the limit, unsigned, before the offset is added. A request with A greater than or equal to the limit produces addrFault high one clock later, and memValid stays low.
- R3: After reset, offset, limit and page-table base are zero and memValid, addrFault and privFault are low. Every request therefore faults until the limit is written.
- R4: A privileged write loads the register chosen by cfgSel: 0 selects the offset, 1 the limit (low AW+1 bits of cfgData), 2 the page-table base. The new value is used from the next clock onward.
- R5: A write with cfgPriv low changes no register. privFault goes high for exactly one clock, one clock after the write.
- R6: ptBase always shows the page-table base register.
- R7: A privileged write with cfgSel equal to 3 changes no register and raises no fault.
- R8: Each request produces exactly one of memValid or addrFault one clock later. A cycle with no request produces neither.
- R9: A request presented in the same cycle as a register write is judged and relocated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Real-mode request present |
| reqAddr | input | AW | Untranslated real address |
| reqWrite | input | 1 | 1 = store, 0 = load |
| cfgValid | input | 1 | Register write present |
| cfgPriv | input | 1 | 1 = write issued by privileged firmware |
| cfgSel | input | 2 | Target register: 0 offset, 1 limit, 2 page-table base, 3 none |
| cfgData | input | PAW | Write data |
| memValid | output | 1 | Relocated request to memory |
| memAddr | output | PAW | Relocated physical address |
| memWrite | output | 1 | Write flag of the forwarded request |
| addrFault | output | 1 | One-cycle addressing-fault pulse |
| privFault | output | 1 | One-cycle privilege-violation pulse |
| ptBase | output | PAW | Page-table base register |

## Verification
Two cases are hard to reach from the ports. The first is the boundary where the address equals the limit. The second is the same case combined with a sum that wraps past the top of physical space. The bench reaches both by sweeping every real address of a narrow configuration against several limit values, including zero and the full span. It pairs these limits with offsets that make the sum wrap. A further hard case is a register write that lands in the same cycle as a request. The bench drives both in a single cycle, then confirms the old limit governed that request and the new limit governs the next one.

// File: rtl/rru_pkg.sv
package rru_pkg;

  typedef enum logic [1:0] {
    SEL_OFFSET = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_PTBASE = 2'd2,
    SEL_NONE   = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic loadOffset;
    logic loadLimit;
    logic loadPtBase;
    logic passReq;
    logic faultReq;
    logic refuseCfg;
  } ctrlStrobe_t;

endpackage

// File: rtl/rru_ctrl.sv
module rru_ctrl
  import rru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        inRange,
  input  logic        cfgValid,
  input  logic        cfgPriv,
  input  logic [1:0]  cfgSel,
  output ctrlStrobe_t strobe,
  output logic        memValid,
  output logic        addrFault,
  output logic        privFault
);

  always_comb begin
    strobe = '0;
    if (cfgValid && cfgPriv) begin
      unique case (cfgSel_e'(cfgSel))
        SEL_OFFSET: strobe.loadOffset = 1'b1;
        SEL_LIMIT:  strobe.loadLimit  = 1'b1;
        SEL_PTBASE: strobe.loadPtBase = 1'b1;
        default:    ;
      endcase
    end
    strobe.refuseCfg = cfgValid && !cfgPriv;
    strobe.passReq   = reqValid && inRange;
    strobe.faultReq  = reqValid && !inRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid  <= 1'b0;
      addrFault <= 1'b0;
      privFault <= 1'b0;
    end else begin
      memValid  <= strobe.passReq;
      addrFault <= strobe.faultReq;
      privFault <= strobe.refuseCfg;
    end
  end

endmodule

// File: rtl/rru_datapath.sv
module rru_datapath
  import rru_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PAW = 24,
  localparam int LW = AW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobe_t    strobe,
  input  logic [AW-1:0]  reqAddr,
  input  logic           reqWrite,
  input  logic [PAW-1:0] cfgData,
  output logic           inRange,
  output logic [PAW-1:0] memAddr,
  output logic           memWrite,
  output logic [PAW-1:0] ptBase,
  output logic [PAW-1:0] offsetVal,
  output logic [LW-1:0]  limitVal
);

  logic [PAW-1:0] offsetQ;
  logic [LW-1:0]  limitQ;
  logic [PAW-1:0] ptBaseQ;
  logic [PAW-1:0] relocSum;

  // unsigned compare on the untranslated address
  assign inRange  = {1'b0, reqAddr} < limitQ;
  assign relocSum = offsetQ + PAW'(reqAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
      limitQ  <= '0;
      ptBaseQ <= '0;
    end else begin
      if (strobe.loadOffset) offsetQ <= cfgData;
      if (strobe.loadLimit)  limitQ  <= LW'(cfgData);
      if (strobe.loadPtBase) ptBaseQ <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWrite <= 1'b0;
    end else if (strobe.passReq) begin
      memAddr  <= relocSum;
      memWrite <= reqWrite;
    end
  end

  assign ptBase    = ptBaseQ;
  assign offsetVal = offsetQ;
  assign limitVal  = limitQ;

endmodule

// File: rtl/real_reloc_unit.sv
module real_reloc_unit
  import rru_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PAW = 24
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [AW-1:0]  reqAddr,
  input  logic           reqWrite,
  input  logic           cfgValid,
  input  logic           cfgPriv,
  input  logic [1:0]     cfgSel,
  input  logic [PAW-1:0] cfgData,
  output logic           memValid,
  output logic [PAW-1:0] memAddr,
  output logic           memWrite,
  output logic           addrFault,
  output logic           privFault,
  output logic [PAW-1:0] ptBase
);

  localparam int LW = AW + 1;

  ctrlStrobe_t    strobe;
  logic           inRange;
  logic [PAW-1:0] offsetVal;
  logic [LW-1:0]  limitVal;

  rru_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .inRange   (inRange),
    .cfgValid  (cfgValid),
    .cfgPriv   (cfgPriv),
    .cfgSel    (cfgSel),
    .strobe    (strobe),
    .memValid  (memValid),
    .addrFault (addrFault),
    .privFault (privFault)
  );

  rru_datapath #(.AW(AW), .PAW(PAW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .cfgData   (cfgData),
    .inRange   (inRange),
    .memAddr   (memAddr),
    .memWrite  (memWrite),
    .ptBase    (ptBase),
    .offsetVal (offsetVal),
    .limitVal  (limitVal)
  );

endmodule

// File: rtl/rru_checker.sv
module rru_checker #(
  parameter int AW  = 16,
  parameter int PAW = 24,
  localparam int LW = AW + 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic [AW-1:0]  reqAddr,
  input logic           cfgValid,
  input logic           cfgPriv,
  input logic [PAW-1:0] ptBase,
  input logic           memValid,
  input logic           addrFault,
  input logic           privFault,
  input logic [LW-1:0]  limitVal
);

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (memValid ^ addrFault));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!memValid && !addrFault));

  // R2
  range_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqAddr} >= limitVal)) |=> (addrFault && !memValid));

  // R5
  refuse_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgPriv) |=> (privFault && $stable(ptBase) && $stable(limitVal)));

  // R5
  no_spurious_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgValid && !cfgPriv) |=> !privFault);

endmodule

bind real_reloc_unit rru_checker #(.AW(AW), .PAW(PAW)) u_chk (.*);

// File: tb/real_reloc_unit_bench.sv
`timescale 1ns/1ps
module real_reloc_unit_bench;

  localparam int AW  = 6;
  localparam int PAW = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           reqValid = 1'b0;
  logic [AW-1:0]  reqAddr = '0;
  logic           reqWrite = 1'b0;
  logic           cfgValid = 1'b0;
  logic           cfgPriv = 1'b0;
  logic [1:0]     cfgSel = '0;
  logic [PAW-1:0] cfgData = '0;
  logic           memValid;
  logic [PAW-1:0] memAddr;
  logic           memWrite;
  logic           addrFault;
  logic           privFault;
  logic [PAW-1:0] ptBase;

  int checks = 0;
  int errors = 0;
  int expOffset = 0;
  int expLimit = 0;
  int expPt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  real_reloc_unit #(.AW(AW), .PAW(PAW)) u_real_reloc_unit (.*);

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // R1 R2 expectation for one request
  task automatic judge(input int a, input bit w, input int lim, input int off, input string req);
    if (a < lim) begin
      check(memValid && !addrFault && memAddr == PAW'(off + a) && memWrite == w, req,
        $sformatf("addr %0d: got v=%0b f=%0b a=%0h w=%0b, exp v=1 f=0 a=%0h w=%0b",
          a, memValid, addrFault, memAddr, memWrite, PAW'(off + a), w));
    end else begin
      check(!memValid && addrFault, req,
        $sformatf("addr %0d lim %0d: got v=%0b f=%0b, exp v=0 f=1",
          a, lim, memValid, addrFault));
    end
  endtask

  task automatic doReq(input int a, input bit w, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = AW'(a); reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
    judge(a, w, expLimit, expOffset, req);
  endtask

  task automatic cfgWrite(input int sel, input int data, input bit priv, input string req);
    @(negedge clk);
    cfgValid = 1'b1; cfgSel = 2'(sel); cfgData = PAW'(data); cfgPriv = priv;
    @(negedge clk);
    cfgValid = 1'b0;
    check(privFault == !priv, req,
      $sformatf("privFault got %0b exp %0b", privFault, !priv));
    if (priv) begin
      if (sel == 0) expOffset = data & ((1 << PAW) - 1);
      if (sel == 1) expLimit = data & ((1 << (AW + 1)) - 1);
      if (sel == 2) expPt = data & ((1 << PAW) - 1);
    end
    check(ptBase == PAW'(expPt), "R6",
      $sformatf("ptBase got %0h exp %0h", ptBase, PAW'(expPt)));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int offs[3];
    int lims[4];
    offs = '{0, 8'h37, 8'hF0};
    lims = '{0, 1, 17, 64};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state
    check(!memValid && !addrFault && !privFault && ptBase == 0, "R3",
      $sformatf("after reset v=%0b f=%0b p=%0b pt=%0h exp all 0",
        memValid, addrFault, privFault, ptBase));
    for (int a = 0; a < 64; a += 9) doReq(a, 1'b0, "R3");

    // R1 R2 R4 sweep over offsets and limits
    for (int i = 0; i < 3; i++) begin
      cfgWrite(0, offs[i], 1'b1, "R4");
      for (int j = 0; j < 4; j++) begin
        cfgWrite(1, lims[j], 1'b1, "R4");
        for (int a = 0; a < 64; a++) doReq(a, a[0], "R2");
      end
    end

    // R4 R6 page-table base
    cfgWrite(2, 8'hA5, 1'b1, "R4");
    cfgWrite(0, 8'h10, 1'b1, "R4");
    cfgWrite(1, 20, 1'b1, "R4");

    // R5 refused writes to each register
    for (int s = 0; s < 4; s++) cfgWrite(s, 8'h3C, 1'b0, "R5");
    check(ptBase == 8'hA5, "R5", $sformatf("ptBase got %0h exp a5", ptBase));
    doReq(19, 1'b1, "R5");
    doReq(20, 1'b0, "R5");
    // R5 pulse lasts one cycle
    @(negedge clk);
    check(!privFault, "R5", $sformatf("privFault got %0b exp 0", privFault));

    // R7 privileged write to unused select
    cfgWrite(3, 8'hFF, 1'b1, "R7");
    doReq(19, 1'b0, "R7");
    doReq(21, 1'b0, "R7");

    // R8 idle cycle
    @(negedge clk);
    check(!memValid && !addrFault, "R8",
      $sformatf("idle got v=%0b f=%0b exp 0 0", memValid, addrFault));

    // R9 write and request in the same cycle
    @(negedge clk);
    cfgValid = 1'b1; cfgPriv = 1'b1; cfgSel = 2'd1; cfgData = '0;
    reqValid = 1'b1; reqAddr = AW'(3); reqWrite = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0; reqValid = 1'b0;
    judge(3, 1'b1, 20, 8'h10, "R9");
    expLimit = 0;
    doReq(3, 1'b1, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule